// File: doc/BRIEF.md
# Synonym Probe Controller for a Virtually Indexed L1 Data Cache

This block controls synonym clean-up in a two-way set-associative L1 data cache. The set index is built from line-offset bits that lie inside the 4 KiB page and from three bits above the page offset. Those three bits come from the virtual address before translation. Because of this, one physical line can be held in any of eight sets, and two virtual names for the same line could each leave a copy in the cache. The cache only has to check for such a copy when a load or store misses.

On a miss, the cache hands the block the virtual set index and the physical tag of the missing line. The block then reads the tag array once per candidate set, covering both ways in each read. It steps the three virtual bits upward from 0 to 7 and keeps the in-page index bits fixed. If it finds a valid entry with the same physical tag in some other candidate set, it clears that entry through the tag array's invalidate port. If the matching entry is in the requesting set itself, it raises a coherence-error flag and leaves the entry in place. When the scan is finished, the block pulses `probe_done`. This tells the refill logic that it may go ahead.

Top module: `synonym_probe`

## Requirements
- R1: A miss is taken on a rising edge where `miss_valid` and `miss_ready` are both high. `miss_ready` is high only when no probe is running. `probe_busy` is high from the first cycle after the accepting edge until `probe_done` pulses.
- R2: The tag-read set is `{k, i}`, where the three high bits k are the virtual bits and the six low bits i are the in-page part of `miss_vidx`. The block issues one tag read per cycle, k = 0 first up to k = 7, in the 8 cycles that follow the accepting edge.
- R3: Read data (`tag_rd_vld`, `tag_rd_ptag`, with way w at bits `w*TAG_W +: TAG_W`) comes one cycle after `tag_rd_en`. A way matches when its valid bit is 1 and its tag equals `miss_ptag`.
- R4: A match in a set whose k differs from the requesting k drives `tag_inv_en` in the cycle the read data is present. In that cycle `tag_inv_set` is the matched set and `tag_inv_way` is the mask of matching ways.
- R5: `alias_hit` is 1 in the `probe_done` cycle exactly when at least one entry was invalidated during that probe.
- R6: A match in the requesting set sets `coh_err` in the `probe_done` cycle and invalidates nothing.
- R7: `probe_done` is a one-cycle pulse. It goes high in the cycle that starts 9 rising edges after the accepting edge.
- R8: No tag read and no invalidate is issued while no probe is running. A `miss_valid` that is raised and dropped while a probe is busy is never accepted.
- R9: After reset, `miss_ready` is 1. `probe_busy`, `probe_done`, `tag_rd_en`, `tag_inv_en`, `alias_hit` and `coh_err` are all 0.
- R10: When no candidate entry matches, both flags are 0 and every cached entry keeps its valid bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Block can accept a miss |
| miss_vidx | input | SET_W (9) | Virtual set index of the missing line |
| miss_ptag | input | TAG_W (28) | Physical address bits above bit 11 |
| tag_rd_en | output | 1 | Tag-array read strobe |
| tag_rd_set | output | SET_W | Set to read |
| tag_rd_vld | input | WAYS (2) | Valid bits returned, one per way |
| tag_rd_ptag | input | WAYS*TAG_W | Tags returned, way w at w*TAG_W |
| tag_inv_en | output | 1 | Invalidate strobe |
| tag_inv_set | output | SET_W | Set to invalidate |
| tag_inv_way | output | WAYS | Ways to invalidate |
| probe_busy | output | 1 | Scan in progress |
| probe_done | output | 1 | One-cycle end-of-scan pulse |
| alias_hit | output | 1 | A synonym was found and removed |
| coh_err | output | 1 | Tag already present at the requesting set |

## Verification
Counting from the edge that accepts a miss, the tag read for virtual value k is on the port k edges later, for k from 0 to 7. Any invalidation for that set comes one edge after its read. `probe_done`, `alias_hit` and `coh_err` are due 9 edges after acceptance. The bench samples at falling edges and counts edges from the accepting one, so each read, invalidate and result is compared in exactly the cycle the timing above predicts. Planted copies are placed in the first candidate set, the last one, a middle one and the requesting set. This exercises the final compare, which happens after the last read has been issued.

// File: rtl/synprobe_pkg.sv
package synprobe_pkg;
   typedef enum logic [1:0] {
      SP_IDLE = 2'd0,
      SP_SCAN = 2'd1,
      SP_LAST = 2'd2
   } sp_state_e;
endpackage

// File: rtl/synprobe_match.sv
module synprobe_match #(
   parameter int WAYS  = 2,
   parameter int TAG_W = 28
) (
   input  logic [WAYS-1:0]       rd_vld,
   input  logic [WAYS*TAG_W-1:0] rd_tag,
   input  logic [TAG_W-1:0]      ref_tag,
   output logic [WAYS-1:0]       hit
);
   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         assign hit[w] = rd_vld[w] && (rd_tag[w*TAG_W +: TAG_W] == ref_tag);
      end
   endgenerate
endmodule

// File: rtl/synprobe_seq.sv
module synprobe_seq
   import synprobe_pkg::*;
#(
   parameter int WAYS    = 2,
   parameter int TAG_W   = 28,
   parameter int ALIAS_W = 3,
   parameter int LOW_W   = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     miss_valid,
   output logic                     miss_ready,
   input  logic [ALIAS_W+LOW_W-1:0] miss_vidx,
   input  logic [TAG_W-1:0]         miss_ptag,
   output logic [TAG_W-1:0]         ref_tag,
   input  logic [WAYS-1:0]          hit,
   output logic                     rd_en,
   output logic [ALIAS_W+LOW_W-1:0] rd_set,
   output logic                     inv_en,
   output logic [ALIAS_W+LOW_W-1:0] inv_set,
   output logic [WAYS-1:0]          inv_way,
   output logic                     busy,
   output logic                     done,
   output logic                     alias_hit,
   output logic                     coh_err
);
   localparam int SET_W = ALIAS_W + LOW_W;
   localparam logic [ALIAS_W-1:0] LAST_K = ALIAS_W'((1 << ALIAS_W) - 1);

   sp_state_e          st_q;
   logic [ALIAS_W-1:0] cnt_q, cmp_k_q, own_k_q;
   logic [LOW_W-1:0]   low_q;
   logic [TAG_W-1:0]   tag_q;
   logic               cmp_vld_q;
   logic               alias_acc_q, coh_acc_q;
   logic               done_q, alias_out_q, coh_out_q;

   logic accept, any_hit, cmp_own, hit_alias, hit_own;

   assign accept    = miss_valid && (st_q == SP_IDLE);
   assign any_hit   = |hit;
   assign cmp_own   = (cmp_k_q == own_k_q);
   assign hit_alias = cmp_vld_q && any_hit && !cmp_own;
   assign hit_own   = cmp_vld_q && any_hit && cmp_own;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= SP_IDLE;
         cnt_q       <= '0;
         cmp_k_q     <= '0;
         own_k_q     <= '0;
         low_q       <= '0;
         tag_q       <= '0;
         cmp_vld_q   <= 1'b0;
         alias_acc_q <= 1'b0;
         coh_acc_q   <= 1'b0;
         done_q      <= 1'b0;
         alias_out_q <= 1'b0;
         coh_out_q   <= 1'b0;
      end else begin
         done_q    <= 1'b0;
         cmp_vld_q <= (st_q == SP_SCAN);
         cmp_k_q   <= cnt_q;
         case (st_q)
            SP_IDLE: begin
               if (accept) begin
                  low_q       <= miss_vidx[LOW_W-1:0];
                  own_k_q     <= miss_vidx[SET_W-1:LOW_W];
                  tag_q       <= miss_ptag;
                  cnt_q       <= '0;
                  alias_acc_q <= 1'b0;
                  coh_acc_q   <= 1'b0;
                  alias_out_q <= 1'b0;
                  coh_out_q   <= 1'b0;
                  st_q        <= SP_SCAN;
               end
            end
            SP_SCAN: begin
               cnt_q       <= cnt_q + 1'b1;
               alias_acc_q <= alias_acc_q | hit_alias;
               coh_acc_q   <= coh_acc_q | hit_own;
               if (cnt_q == LAST_K) st_q <= SP_LAST;
            end
            SP_LAST: begin
               alias_out_q <= alias_acc_q | hit_alias;
               coh_out_q   <= coh_acc_q | hit_own;
               done_q      <= 1'b1;
               st_q        <= SP_IDLE;
            end
            default: st_q <= SP_IDLE;
         endcase
      end
   end

   assign miss_ready = (st_q == SP_IDLE);
   assign busy       = (st_q != SP_IDLE);
   assign ref_tag    = tag_q;
   assign rd_en      = (st_q == SP_SCAN);
   assign rd_set     = {cnt_q, low_q};
   assign inv_en     = hit_alias;
   assign inv_set    = {cmp_k_q, low_q};
   assign inv_way    = hit & {WAYS{hit_alias}};
   assign done       = done_q;
   assign alias_hit  = alias_out_q;
   assign coh_err    = coh_out_q;
endmodule

// File: rtl/synonym_probe.sv
module synonym_probe #(
   parameter int PA_W       = 40,
   parameter int PAGE_SHIFT = 12,
   parameter int LINE_SHIFT = 6,
   parameter int ALIAS_W    = 3,
   parameter int WAYS       = 2,
   localparam int TAG_W     = PA_W - PAGE_SHIFT,
   localparam int LOW_W     = PAGE_SHIFT - LINE_SHIFT,
   localparam int SET_W     = LOW_W + ALIAS_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  miss_valid,
   output logic                  miss_ready,
   input  logic [SET_W-1:0]      miss_vidx,
   input  logic [TAG_W-1:0]      miss_ptag,
   output logic                  tag_rd_en,
   output logic [SET_W-1:0]      tag_rd_set,
   input  logic [WAYS-1:0]       tag_rd_vld,
   input  logic [WAYS*TAG_W-1:0] tag_rd_ptag,
   output logic                  tag_inv_en,
   output logic [SET_W-1:0]      tag_inv_set,
   output logic [WAYS-1:0]       tag_inv_way,
   output logic                  probe_busy,
   output logic                  probe_done,
   output logic                  alias_hit,
   output logic                  coh_err
);
   generate
      if (ALIAS_W < 1 || ALIAS_W > 6) begin : g_bad_alias
         $error("synonym_probe: ALIAS_W must be 1..6");
      end
      if (WAYS < 1) begin : g_bad_ways
         $error("synonym_probe: WAYS must be at least 1");
      end
      if (PAGE_SHIFT <= LINE_SHIFT || PA_W <= PAGE_SHIFT) begin : g_bad_geom
         $error("synonym_probe: inconsistent address geometry");
      end
   endgenerate

   logic [TAG_W-1:0] ref_tag;
   logic [WAYS-1:0]  way_hit;

   synprobe_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
      .rd_vld  (tag_rd_vld),
      .rd_tag  (tag_rd_ptag),
      .ref_tag (ref_tag),
      .hit     (way_hit)
   );

   synprobe_seq #(.WAYS(WAYS), .TAG_W(TAG_W), .ALIAS_W(ALIAS_W), .LOW_W(LOW_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .miss_valid (miss_valid),
      .miss_ready (miss_ready),
      .miss_vidx  (miss_vidx),
      .miss_ptag  (miss_ptag),
      .ref_tag    (ref_tag),
      .hit        (way_hit),
      .rd_en      (tag_rd_en),
      .rd_set     (tag_rd_set),
      .inv_en     (tag_inv_en),
      .inv_set    (tag_inv_set),
      .inv_way    (tag_inv_way),
      .busy       (probe_busy),
      .done       (probe_done),
      .alias_hit  (alias_hit),
      .coh_err    (coh_err)
   );
endmodule

// File: rtl/synonym_probe_chk.sv
module synonym_probe_chk #(
   parameter int ALIAS_W = 3,
   parameter int LOW_W   = 6,
   localparam int SET_W  = ALIAS_W + LOW_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             miss_valid,
   input logic             miss_ready,
   input logic [SET_W-1:0] miss_vidx,
   input logic             probe_busy,
   input logic             probe_done,
   input logic             tag_rd_en,
   input logic [SET_W-1:0] tag_rd_set,
   input logic             tag_inv_en,
   input logic [SET_W-1:0] tag_inv_set
);
   logic [SET_W-1:0] own_set_q;

   always_ff @(posedge clk) begin
      if (!rst_n) own_set_q <= '0;
      else if (miss_valid && miss_ready) own_set_q <= miss_vidx;
   end

   // R1: an accepted miss makes the block busy on the next cycle
   a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_valid && miss_ready) |=> probe_busy);

   // R2: virtual bits of the read set step up by one per cycle
   a_r2_read_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_rd_en && tag_rd_set[SET_W-1:LOW_W] != {ALIAS_W{1'b1}}) |=>
      (tag_rd_en && tag_rd_set[SET_W-1:LOW_W] ==
                    ($past(tag_rd_set[SET_W-1:LOW_W]) + ALIAS_W'(1))));

   // R2: in-page bits of the read set follow the accepted request
   a_r2_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
      tag_rd_en |-> (tag_rd_set[LOW_W-1:0] == own_set_q[LOW_W-1:0]));

   // R6: the requesting set is never invalidated
   a_r6_no_self_inv: assert property (@(posedge clk) disable iff (!rst_n)
      tag_inv_en |-> (tag_inv_set != own_set_q));

   // R7: done lasts exactly one cycle
   a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      probe_done |=> !probe_done);

   // R8: no tag traffic when no probe is running
   a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !probe_busy |-> (!tag_rd_en && !tag_inv_en));
endmodule

bind synonym_probe synonym_probe_chk #(.ALIAS_W(ALIAS_W), .LOW_W(LOW_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .miss_valid  (miss_valid),
   .miss_ready  (miss_ready),
   .miss_vidx   (miss_vidx),
   .probe_busy  (probe_busy),
   .probe_done  (probe_done),
   .tag_rd_en   (tag_rd_en),
   .tag_rd_set  (tag_rd_set),
   .tag_inv_en  (tag_inv_en),
   .tag_inv_set (tag_inv_set)
);

// File: tb/sim_synonym_probe.sv
`timescale 1ns/1ps
module sim_synonym_probe;
   localparam int SET_W = 9;
   localparam int TAG_W = 28;
   localparam int WAYS  = 2;
   localparam int NSET  = 1 << SET_W;
   localparam int DONE_LAT = 9;

   typedef struct packed {
      logic [8:0]  vidx;
      logic [27:0] ptag;
      logic        plant;
      logic [2:0]  p_k;
      logic        p_way;
      logic        e_alias;
      logic        e_coh;
   } vec_t;

   localparam int NVEC = 6;
   localparam vec_t TBL [NVEC] = '{
      '{9'h0A5, 28'h0001234, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0},
      '{9'h0A5, 28'h0005678, 1'b1, 3'd5, 1'b1, 1'b1, 1'b0},
      '{9'h1C0, 28'h0009ABC, 1'b1, 3'd0, 1'b0, 1'b1, 1'b0},
      '{9'h03F, 28'h000BEEF, 1'b1, 3'd7, 1'b1, 1'b1, 1'b0},
      '{9'h111, 28'h000CAFE, 1'b1, 3'd4, 1'b0, 1'b0, 1'b1},
      '{9'h0A5, 28'h0005678, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic miss_valid = 1'b0;
   logic [SET_W-1:0] miss_vidx = '0;
   logic [TAG_W-1:0] miss_ptag = '0;
   logic miss_ready, tag_rd_en, tag_inv_en, probe_busy, probe_done, alias_hit, coh_err;
   logic [SET_W-1:0] tag_rd_set, tag_inv_set;
   logic [WAYS-1:0] tag_inv_way;
   logic [WAYS-1:0] tag_rd_vld;
   logic [WAYS*TAG_W-1:0] tag_rd_ptag;

   logic vmem [NSET][WAYS];
   logic [TAG_W-1:0] tmem [NSET][WAYS];
   logic fill_en = 1'b0;
   logic plant_en = 1'b0;
   logic [SET_W-1:0] plant_set = '0;
   logic plant_way = 1'b0;
   logic [TAG_W-1:0] plant_tag = '0;

   int checks = 0;
   int fails = 0;

   always #2 clk = ~clk;

   synonym_probe u0 (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
      .miss_vidx(miss_vidx), .miss_ptag(miss_ptag), .tag_rd_en(tag_rd_en),
      .tag_rd_set(tag_rd_set), .tag_rd_vld(tag_rd_vld), .tag_rd_ptag(tag_rd_ptag),
      .tag_inv_en(tag_inv_en), .tag_inv_set(tag_inv_set), .tag_inv_way(tag_inv_way),
      .probe_busy(probe_busy), .probe_done(probe_done), .alias_hit(alias_hit),
      .coh_err(coh_err)
   );

   // tag-array model: registered read, invalidate, bench fill and plant
   always @(posedge clk) begin
      if (tag_rd_en) begin
         for (int w = 0; w < WAYS; w++) begin
            tag_rd_vld[w] <= vmem[tag_rd_set][w];
            tag_rd_ptag[w*TAG_W +: TAG_W] <= tmem[tag_rd_set][w];
         end
      end
      if (fill_en) begin
         for (int s = 0; s < NSET; s++)
            for (int w = 0; w < WAYS; w++) begin
               vmem[s][w] <= 1'b1;
               tmem[s][w] <= 28'hF000000 | TAG_W'(s * 2 + w);
            end
      end else if (plant_en) begin
         vmem[plant_set][plant_way] <= 1'b1;
         tmem[plant_set][plant_way] <= plant_tag;
      end
      if (tag_inv_en) begin
         for (int w = 0; w < WAYS; w++)
            if (tag_inv_way[w]) vmem[tag_inv_set][w] <= 1'b0;
      end
   end

   task automatic chk(input logic ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic plant(input logic [SET_W-1:0] s, input logic w, input logic [TAG_W-1:0] t);
      @(negedge clk);
      plant_set = s; plant_way = w; plant_tag = t; plant_en = 1'b1;
      @(negedge clk);
      plant_en = 1'b0;
   endtask

   // launches one miss; k counts edges after the accepting edge
   task automatic run_miss(input logic [SET_W-1:0] vidx, input logic [TAG_W-1:0] ptag,
                           input logic hold, input logic [SET_W-1:0] watch,
                           output int lat, output logic order_ok, output logic busy_ok,
                           output int inv_cnt, output logic r_alias, output logic r_coh);
      int k;
      int next_k;
      @(negedge clk);
      miss_valid = 1'b1; miss_vidx = vidx; miss_ptag = ptag;
      @(negedge clk);
      if (hold) begin
         miss_vidx = 9'h1FF; miss_ptag = 28'h0FFFFFF;
      end else begin
         miss_valid = 1'b0;
      end
      k = 0; next_k = 0; order_ok = 1'b1; busy_ok = 1'b1; inv_cnt = 0;
      while (!probe_done && k < 20) begin
         if (!probe_busy || (hold && miss_ready)) busy_ok = 1'b0;
         if (tag_rd_en) begin
            if (k != next_k || tag_rd_set != {3'(next_k), vidx[5:0]}) order_ok = 1'b0;
            next_k++;
         end
         if (tag_inv_en && tag_inv_set == watch) inv_cnt++;
         @(negedge clk);
         k++;
         if (hold && k == 6) miss_valid = 1'b0;
      end
      if (next_k != 8) order_ok = 1'b0;
      lat = k;
      r_alias = alias_hit;
      r_coh = coh_err;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      int lat, inv_cnt;
      logic order_ok, busy_ok, r_alias, r_coh;
      logic [SET_W-1:0] pset;
      logic quiet;

      repeat (3) @(negedge clk);
      fill_en = 1'b1;
      @(negedge clk);
      fill_en = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk(miss_ready && !probe_busy && !probe_done && !tag_rd_en && !tag_inv_en
          && !alias_hit && !coh_err, "R9 reset outputs",
          {miss_ready, probe_busy, probe_done, tag_rd_en, tag_inv_en, alias_hit, coh_err},
          7'b1000000);
      // R8 idle: no tag reads
      quiet = 1'b1;
      repeat (5) begin
         @(negedge clk);
         if (tag_rd_en || tag_inv_en) quiet = 1'b0;
      end
      chk(quiet, "R8 idle no tag traffic", !quiet, 0);

      for (int v = 0; v < NVEC; v++) begin
         pset = {TBL[v].p_k, TBL[v].vidx[5:0]};
         if (TBL[v].plant) plant(pset, TBL[v].p_way, TBL[v].ptag);
         run_miss(TBL[v].vidx, TBL[v].ptag, 1'b0, pset, lat, order_ok, busy_ok,
                  inv_cnt, r_alias, r_coh);
         chk(lat == DONE_LAT, "R7 done latency", lat, DONE_LAT);
         chk(order_ok, "R2 read order", order_ok, 1);
         chk(busy_ok, "R1 busy during scan", busy_ok, 1);
         chk(r_alias == TBL[v].e_alias, "R5 alias_hit", r_alias, TBL[v].e_alias);
         chk(r_coh == TBL[v].e_coh, "R6 coh_err", r_coh, TBL[v].e_coh);
         chk(miss_ready, "R1 ready in done cycle", miss_ready, 1);
         if (TBL[v].plant) begin
            // R4 copy gone when an alias; R6 copy kept at own set; R3 match rule
            chk(vmem[pset][TBL[v].p_way] == !TBL[v].e_alias, "R4 planted entry state",
                vmem[pset][TBL[v].p_way], !TBL[v].e_alias);
            chk(inv_cnt == int'(TBL[v].e_alias), "R4 invalidate count", inv_cnt,
                TBL[v].e_alias);
         end else begin
            chk(!r_alias && !r_coh, "R10 no match flags", {r_alias, r_coh}, 0);
         end
         @(negedge clk);
         chk(!probe_done, "R7 done one cycle", probe_done, 0);
      end

      // R10: background entries all intact
      quiet = 1'b1;
      for (int s = 0; s < NSET; s++)
         for (int w = 0; w < WAYS; w++)
            if (!vmem[s][w] && !(s == 9'h165 && w == 1) && !(s == 9'h000 && w == 0)
                && !(s == 9'h1FF && w == 1)) quiet = 1'b0;
      chk(quiet, "R10 unrelated entries kept", !quiet, 0);

      // R8 / R1: request held during busy is ignored
      plant(9'h0E5, 1'b0, 28'h0007777);
      run_miss(9'h0A5, 28'h0007777, 1'b1, 9'h0E5, lat, order_ok, busy_ok,
               inv_cnt, r_alias, r_coh);
      chk(busy_ok, "R1 not ready while busy", busy_ok, 1);
      chk(order_ok, "R8 scan keeps first request", order_ok, 1);
      chk(r_alias && inv_cnt == 1, "R4 alias with held request", {r_alias, 4'(inv_cnt)}, 5'h11);
      quiet = 1'b1;
      repeat (4) begin
         @(negedge clk);
         if (tag_rd_en || probe_busy) quiet = 1'b0;
      end
      chk(quiet, "R8 busy-time request not accepted", !quiet, 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule